// File: doc/BRIEF.md
# Instruction Sequencer Program-Counter Control

This block steps a program counter through a small instruction memory in a data-acquisition device. A configuration register supplies two control levels: a run request and a sequencer clear. While the run request is high the block fetches one instruction slot at a time. It then hands that slot to a conversion engine through a one-cycle execute strobe. It waits for the engine's done response, then advances the counter. The counter wraps from the last slot back to slot 0.

Each fetched instruction word carries a pause flag. A flagged slot stops the sequencer before that slot executes, and the block reports the stop with a one-cycle pause interrupt. Dropping the run request and raising it again resumes the sequencer at the paused slot. The block also compares every fetched address with a trigger address and emits a one-cycle match interrupt before the slot executes. A match never stops sequencing. When the trigger address is 0, the first fetch of slot 0 after a clear does not count as a match. The interrupt controller and the conversion engine sit outside the block.

Top module: `seq_ctrl`

## Requirements
- R1: After the hardware reset, `fetch_addr` is 0 and no execute strobe or interrupt pulse is issued while `cfg_run` stays 0.
- R2: Slots are fetched in the order 0,1,...,7 and then 0 again. `fetch_addr` advances by one (wrapping 7 to 0) only on an `exec_done` received while a slot is executing, and otherwise holds.
- R3: A fetched slot whose pause flag (bit 1 of `instr_word`) is 0 produces exactly one `exec_stb` pulse. `fetch_addr` equals that slot's address while the strobe is high.
- R4: For a nonzero trigger, `irq_match` pulses on every fetch of the slot equal to `trig_addr`, including the first one. During the pulse `fetch_addr` equals the trigger, and sequencing continues afterwards.
- R5: With `trig_addr` = 0, the first fetch of slot 0 after a clear raises no match pulse. The second and every later fetch of slot 0 do raise one.
- R6: A fetched slot with bit 1 of `instr_word` set raises `irq_pause` and no `exec_stb`. The sequencer then stays stopped with `fetch_addr` on that slot.
- R7: While paused, a 0-to-1 transition of `cfg_run` executes the paused slot with one `exec_stb`. It raises no second pause pulse and no second match pulse for that slot, and sequencing then continues.
- R8: Lowering `cfg_run` while a slot executes lets that slot finish and advance the counter, and then no further slot is fetched. Raising `cfg_run` again continues from the next slot.
- R9: `cfg_clear` = 1 aborts the sequencer in any state, returns `fetch_addr` to 0 and re-arms the first-pass skip of R5.
- R10: `exec_stb`, `irq_match` and `irq_pause` are never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cfg_run | input | 1 | Run request level from the configuration register |
| cfg_clear | input | 1 | Sequencer clear level from the configuration register |
| trig_addr | input | 3 | Slot address that raises the match interrupt |
| instr_word | input | 8 | Instruction word read at `fetch_addr`; bit 1 is the pause flag |
| exec_done | input | 1 | Conversion engine finished the current slot |
| fetch_addr | output | 3 | Program counter, the slot being fetched or executed |
| exec_stb | output | 1 | One-cycle start pulse to the conversion engine |
| irq_match | output | 1 | One-cycle trigger-address match interrupt |
| irq_pause | output | 1 | One-cycle pause interrupt |

## Verification
The bench builds the block with its default parameters: eight slots, an 8-bit instruction word with the pause flag at bit 1, and the first-pass skip for trigger 0 enabled. With these values a run of sixteen slots covers two full wraps, so the bench can confirm that a trigger of 0 is skipped on the first pass and counted on the second. The power-of-two depth selects the natural-overflow counter variant, and the 3-bit trigger reaches every slot including the wrap boundary at 7. A second run after a clear then shows that the skip has been re-armed.

// File: rtl/seq_ctrl_pkg.sv
package seq_ctrl_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_FETCH  = 2'd1,
      SQ_EXEC   = 2'd2,
      SQ_PAUSED = 2'd3
   } sq_state_e;

endpackage

// File: rtl/seq_pc_reg.sv
module seq_pc_reg #(
   parameter int DEPTH = 8,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   output logic [AW-1:0] pc
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   logic [AW-1:0] pc_inc;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("seq_pc_reg: DEPTH must be at least 2");
      end
      if ((1 << AW) == DEPTH) begin : g_pow2
         // natural overflow wraps the counter
         assign pc_inc = pc + AW'(1);
      end else begin : g_npow2
         assign pc_inc = (pc == LAST) ? '0 : pc + AW'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc <= '0;
      end else if (clr) begin
         pc <= '0;
      end else if (adv) begin
         pc <= pc_inc;
      end
   end

endmodule

// File: rtl/seq_trig_cmp.sv
module seq_trig_cmp #(
   parameter int AW = 3,
   parameter bit SKIP_FIRST_ZERO = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          fetch_valid,
   input  logic [AW-1:0] pc,
   input  logic [AW-1:0] trig,
   output logic          match
);

   logic addr_eq;

   assign addr_eq = (pc == trig);

   generate
      if (AW < 1) begin : g_bad_aw
         $error("seq_trig_cmp: AW must be at least 1");
      end
      if (SKIP_FIRST_ZERO) begin : g_skip
         logic zero_seen;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               zero_seen <= 1'b0;
            end else if (clr) begin
               zero_seen <= 1'b0;
            end else if (fetch_valid && (pc == '0)) begin
               zero_seen <= 1'b1;
            end
         end

         assign match = fetch_valid && addr_eq && ((trig != '0) || zero_seen);

         // R5: after a clear, the first zero fetch never matches
         assert_zero_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(clr) |-> !match || (trig != '0));
      end else begin : g_plain
         assign match = fetch_valid && addr_eq;
      end
   endgenerate

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
   import seq_ctrl_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run,
   input  logic      clear,
   input  logic      pause_bit,
   input  logic      match_in,
   input  logic      done,
   output sq_state_e state,
   output logic      fetch_valid,
   output logic      pc_clr,
   output logic      pc_adv,
   output logic      stb,
   output logic      irq_match,
   output logic      irq_pause
);

   logic run_q;
   logic run_rise;

   assign run_rise    = run && !run_q;
   assign fetch_valid = (state == SQ_FETCH) && run && !clear;
   assign pc_clr      = clear;
   assign pc_adv      = (state == SQ_EXEC) && done && !clear;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= SQ_IDLE;
         run_q     <= 1'b0;
         stb       <= 1'b0;
         irq_match <= 1'b0;
         irq_pause <= 1'b0;
      end else begin
         run_q     <= run;
         stb       <= 1'b0;
         irq_match <= 1'b0;
         irq_pause <= 1'b0;
         if (clear) begin
            state <= SQ_IDLE;
         end else begin
            unique case (state)
               SQ_IDLE: begin
                  if (run) state <= SQ_FETCH;
               end
               SQ_FETCH: begin
                  if (!run) begin
                     state <= SQ_IDLE;
                  end else begin
                     irq_match <= match_in;
                     if (pause_bit) begin
                        state     <= SQ_PAUSED;
                        irq_pause <= 1'b1;
                     end else begin
                        state <= SQ_EXEC;
                        stb   <= 1'b1;
                     end
                  end
               end
               SQ_EXEC: begin
                  if (done) state <= run ? SQ_FETCH : SQ_IDLE;
               end
               SQ_PAUSED: begin
                  if (run_rise) begin
                     state <= SQ_EXEC;
                     stb   <= 1'b1;
                  end
               end
               default: state <= SQ_IDLE;
            endcase
         end
      end
   end

   // R10: pulses last a single cycle
   assert_stb_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stb |=> !stb);
   assert_match_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_match |=> !irq_match);
   assert_pause_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pause |=> !irq_pause);
   // R6: a pause never starts execution in the same cycle
   assert_pause_no_exec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_pause |-> !stb && (state == SQ_PAUSED));
   // R9: clear always lands in idle
   assert_clear_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (state == SQ_IDLE));

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
   import seq_ctrl_pkg::*;
#(
   parameter int DEPTH           = 8,
   parameter int INSTR_W         = 8,
   parameter int PAUSE_BIT       = 1,
   parameter bit SKIP_FIRST_ZERO = 1'b1,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_run,
   input  logic               cfg_clear,
   input  logic [AW-1:0]      trig_addr,
   input  logic [INSTR_W-1:0] instr_word,
   input  logic               exec_done,
   output logic [AW-1:0]      fetch_addr,
   output logic               exec_stb,
   output logic               irq_match,
   output logic               irq_pause
);

   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   generate
      if (PAUSE_BIT < 0 || PAUSE_BIT >= INSTR_W) begin : g_bad_pause
         $error("seq_ctrl: PAUSE_BIT outside the instruction word");
      end
   endgenerate

   sq_state_e state;
   logic      fetch_valid;
   logic      pc_clr;
   logic      pc_adv;
   logic      match;
   logic      pause_bit;

   assign pause_bit = instr_word[PAUSE_BIT];

   seq_pc_reg #(.DEPTH(DEPTH)) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (pc_clr),
      .adv   (pc_adv),
      .pc    (fetch_addr)
   );

   seq_trig_cmp #(.AW(AW), .SKIP_FIRST_ZERO(SKIP_FIRST_ZERO)) u_trig (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr         (pc_clr),
      .fetch_valid (fetch_valid),
      .pc          (fetch_addr),
      .trig        (trig_addr),
      .match       (match)
   );

   seq_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .run         (cfg_run),
      .clear       (cfg_clear),
      .pause_bit   (pause_bit),
      .match_in    (match),
      .done        (exec_done),
      .state       (state),
      .fetch_valid (fetch_valid),
      .pc_clr      (pc_clr),
      .pc_adv      (pc_adv),
      .stb         (exec_stb),
      .irq_match   (irq_match),
      .irq_pause   (irq_pause)
   );

   // R2: a completed slot moves the counter forward by one, wrapping
   assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_EXEC) && exec_done && !cfg_clear |=>
      fetch_addr == (($past(fetch_addr) == LAST) ? '0 : $past(fetch_addr) + AW'(1)));
   // R4: a match pulse points at the trigger slot
   assert_match_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_match |-> fetch_addr == $past(trig_addr));
   // R6: a paused sequencer keeps its slot
   assert_pause_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == SQ_PAUSED) && !cfg_clear |=> $stable(fetch_addr));
   // R9: clear returns the counter to slot 0
   assert_clear_pc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_clear |=> fetch_addr == '0);

endmodule

// File: tb/seq_ctrl_tb.sv
module seq_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_run = 1'b0;
   logic       cfg_clear = 1'b0;
   logic [2:0] trig_addr = 3'd0;
   logic [7:0] instr_word;
   logic       exec_done = 1'b0;
   logic [2:0] fetch_addr;
   logic       exec_stb, irq_match, irq_pause;

   logic [7:0] pmask = 8'h00;
   int checks = 0, failures = 0;
   bit auto_done = 1'b1;

   int ex_log [0:255];
   int m_log  [0:255];
   int p_log  [0:255];
   int ex_n = 0, m_n = 0, p_n = 0, pulse_err = 0;

   always #5 clk = ~clk;

   assign instr_word = {6'b0, pmask[fetch_addr], 1'b0};

   seq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_run(cfg_run), .cfg_clear(cfg_clear),
      .trig_addr(trig_addr), .instr_word(instr_word), .exec_done(exec_done),
      .fetch_addr(fetch_addr), .exec_stb(exec_stb), .irq_match(irq_match),
      .irq_pause(irq_pause)
   );

   // event monitor, sampled away from the active edge
   initial begin
      logic ps, pm, pp;
      ps = 0; pm = 0; pp = 0;
      forever begin
         @(negedge clk);
         if (exec_stb  && ex_n < 256) begin ex_log[ex_n] = fetch_addr; ex_n++; end
         if (irq_match && m_n  < 256) begin m_log[m_n]   = fetch_addr; m_n++;  end
         if (irq_pause && p_n  < 256) begin p_log[p_n]   = fetch_addr; p_n++;  end
         if ((ps && exec_stb) || (pm && irq_match) || (pp && irq_pause)) pulse_err++;
         ps = exec_stb; pm = irq_match; pp = irq_pause;
      end
   end

   // conversion engine model: done two cycles after the strobe
   initial begin
      forever begin
         @(negedge clk);
         if (exec_stb && auto_done) begin
            @(negedge clk);
            exec_done = 1'b1;
            @(negedge clk);
            exec_done = 1'b0;
         end
      end
   end

   initial begin
      #(200000 * 10);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_ex(input int n);
      for (int i = 0; i < 4000 && ex_n < n; i++) @(negedge clk);
   endtask

   task automatic clear_seq();
      @(negedge clk);
      cfg_run = 1'b0;
      cfg_clear = 1'b1;
      @(negedge clk);
      cfg_clear = 1'b0;
      cycles(2);
      ex_n = 0; m_n = 0; p_n = 0;
   endtask

   task automatic t_reset_state();
      int e0;
      e0 = ex_n;
      chk(fetch_addr == 3'd0, "R1 fetch_addr after reset", fetch_addr, 0);
      cycles(6);
      chk(ex_n == e0 && m_n == 0 && p_n == 0, "R1 no pulses while idle", ex_n + m_n + p_n, 0);
   endtask

   task automatic t_sequence();
      bit order_ok;
      clear_seq();
      trig_addr = 3'd5;
      pmask = 8'h00;
      cfg_run = 1'b1;
      wait_ex(10);
      cfg_run = 1'b0;
      cycles(8);
      chk(ex_n == 10, "R3 one strobe per slot", ex_n, 10);
      order_ok = 1'b1;
      for (int i = 0; i < 10; i++) if (ex_log[i] != (i % 8)) order_ok = 1'b0;
      chk(order_ok, "R2 fetch order with wrap", ex_log[8], 0);
      chk(m_n == 1 && m_log[0] == 5, "R4 match on trigger slot", m_n, 1);
      chk(ex_log[5] == 5 && ex_log[6] == 6, "R4 sequencing continues after match", ex_log[6], 6);
   endtask

   task automatic t_trig_zero();
      clear_seq();
      trig_addr = 3'd0;
      cfg_run = 1'b1;
      wait_ex(16);
      cfg_run = 1'b0;
      cycles(8);
      chk(ex_n == 16, "R5 two passes executed", ex_n, 16);
      chk(m_n == 1, "R5 zero skipped first pass, counted second", m_n, 1);
      chk(m_log[0] == 0, "R5 match address", m_log[0], 0);
      clear_seq();
      cfg_run = 1'b1;
      wait_ex(8);
      cfg_run = 1'b0;
      cycles(8);
      chk(m_n == 0, "R9 skip re-armed by clear", m_n, 0);
   endtask

   task automatic t_pause();
      clear_seq();
      trig_addr = 3'd3;
      pmask = 8'b0000_1000;
      cfg_run = 1'b1;
      for (int i = 0; i < 2000 && p_n < 1; i++) @(negedge clk);
      cycles(6);
      chk(p_n == 1 && p_log[0] == 3, "R6 pause raised on slot 3", p_log[0], 3);
      chk(ex_n == 3, "R6 paused slot not executed", ex_n, 3);
      chk(fetch_addr == 3'd3, "R6 counter held on paused slot", fetch_addr, 3);
      chk(m_n == 1, "R4 match raised before pause", m_n, 1);
      cfg_run = 1'b0;
      cycles(2);
      cfg_run = 1'b1;
      wait_ex(6);
      cfg_run = 1'b0;
      cycles(8);
      chk(ex_log[3] == 3, "R7 resume executes paused slot", ex_log[3], 3);
      chk(p_n == 1, "R7 no second pause pulse", p_n, 1);
      chk(m_n == 1, "R7 no second match pulse", m_n, 1);
      chk(ex_log[5] == 5, "R7 sequencing continues", ex_log[5], 5);
      pmask = 8'h00;
   endtask

   task automatic t_stop();
      clear_seq();
      trig_addr = 3'd7;
      cfg_run = 1'b1;
      wait_ex(3);
      cfg_run = 1'b0;
      cycles(10);
      chk(ex_n == 3, "R8 no fetch after stop", ex_n, 3);
      chk(fetch_addr == 3'd3, "R8 current slot finished and advanced", fetch_addr, 3);
      cfg_run = 1'b1;
      wait_ex(4);
      cfg_run = 1'b0;
      cycles(8);
      chk(ex_log[3] == 3, "R8 restart continues at next slot", ex_log[3], 3);
   endtask

   task automatic t_abort();
      clear_seq();
      trig_addr = 3'd0;
      auto_done = 1'b0;
      cfg_run = 1'b1;
      for (int i = 0; i < 40; i++) begin
         if (exec_stb) exec_done = 1'b1;
         @(negedge clk);
         exec_done = 1'b0;
         if (ex_n >= 2) break;
      end
      cycles(3);
      chk(fetch_addr == 3'd1, "R2 counter holds without done", fetch_addr, 1);
      cfg_clear = 1'b1;
      @(negedge clk);
      cfg_clear = 1'b0;
      cfg_run = 1'b0;
      cycles(2);
      chk(fetch_addr == 3'd0, "R9 clear aborts to slot 0", fetch_addr, 0);
      auto_done = 1'b1;
      ex_n = 0; m_n = 0;
      cfg_run = 1'b1;
      wait_ex(2);
      cfg_run = 1'b0;
      cycles(8);
      chk(ex_log[0] == 0, "R9 restart at slot 0", ex_log[0], 0);
      chk(m_n == 0, "R9 first zero skipped after abort", m_n, 0);
   endtask

   initial begin
      cycles(3);
      rst_n = 1'b1;
      cycles(2);
      t_reset_state();
      t_sequence();
      t_trig_zero();
      t_pause();
      t_stop();
      t_abort();
      chk(pulse_err == 0, "R10 single-cycle pulses", pulse_err, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule